// File: doc/BRIEF.md
# DVMA Page-Table Address Translator

This block turns device virtual (DVMA) addresses into physical addresses by walking a single-level page table held in memory. A request gives a starting DVMA address, a byte count, a direction flag, the start of the DVMA window and the table base. The block accepts the request with a one-cycle start pulse when it is idle. For every 4 KB page the transfer touches, it reads one 32-bit table entry over a req/ack read port and checks the entry's permission bits. It then reports one chunk: a physical address, a byte length and the cacheable flag.

The block does not move any data, and it keeps no cache of entries. Whatever performs the copy consumes the chunk pulses. A request ends with a done pulse on its last chunk, or with a fault pulse at the first page whose entry refuses the access. After a fault, no further pages are fetched.

Top module: `dvma_xlate`

## Requirements
- R1: While reset is held and after it is released, busy_o, mem_req_o, chunk_valid_o, fault_o and done_o are all 0.
- R2: The entry for a page is read at address (base << 4) + 4 * ((dva & ~window_start) >> 12), computed modulo 2^32. There is one read per page visited, and pages are visited in ascending order.
- R3: Entry bit 1 is valid, bit 2 is writable, bit 7 is cacheable and bits 26:8 are the physical page number. The chunk address equals page_number * 4096 + (dva mod 4096), and chunk_cache_o equals entry bit 7.
- R4: Each chunk length is the smaller of (4096 - dva mod 4096) and the bytes still left. The next page starts at the address advanced by that length.
- R5: An entry with bit 1 clear produces a fault pulse with fault_code_o = 0, and fault_dva_o gives the DVMA address of the first byte of that page's chunk. That page produces no chunk, no later page is fetched and no done pulse follows.
- R6: On a write request, a valid entry with bit 2 clear produces a fault with fault_code_o = 1, under the same rules as R5. On a read request, bit 2 has no effect.
- R7: A start with length 0 produces done_o in the cycle after the start edge, with no memory read and no chunk.
- R8: done_o pulses together with the chunk that brings the remaining length to 0. In the cycle when done_o or fault_o is seen, busy_o is already 0.
- R9: mem_req_o stays high with a stable mem_addr_o until a cycle in which mem_ack_i is sampled high. One entry is taken per acknowledged cycle.
- R10: A start_i pulse while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| dva_i | input | 32 | Starting DVMA address |
| len_i | input | LEN_W | Byte count |
| write_i | input | 1 | 1 for a device write (needs writable entries) |
| win_start_i | input | 32 | Lowest address of the DVMA window |
| tbl_base_i | input | 32 | Table base register value (shifted left 4) |
| busy_o | output | 1 | Request in progress |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 32 | Entry byte address |
| mem_ack_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 32 | Entry read data |
| chunk_valid_o | output | 1 | One-cycle pulse: chunk fields valid |
| chunk_pa_o | output | 32 | Chunk physical address |
| chunk_len_o | output | LEN_W | Chunk byte count |
| chunk_cache_o | output | 1 | Chunk cacheable flag |
| fault_o | output | 1 | One-cycle pulse: request aborted |
| fault_dva_o | output | 32 | DVMA address of the refused page's chunk |
| fault_code_o | output | 1 | 0 = invalid entry, 1 = write-protected |
| done_o | output | 1 | One-cycle pulse: request finished |

## Verification
A wrong running address or remaining count shows up at the next entry fetch. In the same handshake, mem_addr_o then differs from the page the bench expects, and the next chunk carries the wrong offset or length. A corrupted state register shows up either as a read request when none should exist, which the bench's responder reports at once, or as a missing or extra done or fault pulse. Because every pulse is matched in order against a predicted event list, the first wrong chunk is caught in the cycle in which it appears.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  localparam int unsigned AW         = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PPN_LO     = 8;
  localparam int unsigned PPN_HI     = 26;
  localparam int unsigned BIT_VALID  = 1;
  localparam int unsigned BIT_WRITE  = 2;
  localparam int unsigned BIT_CACHE  = 7;

  typedef enum logic {
    FLT_INVALID = 1'b0,
    FLT_WPROT   = 1'b1
  } flt_code_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } xl_state_e;
endpackage

// File: rtl/dvma_pte_addr.sv
module dvma_pte_addr
  import dvma_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 4
) (
  input  logic [AW-1:0] dva_i,
  input  logic [AW-1:0] win_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] pte_addr_o
);
  localparam int unsigned IDX_SHIFT = PAGE_SHIFT - 2;

  logic [AW-1:0] rel;
  logic [AW-1:0] idx;

  assign rel        = dva_i & ~win_i;
  assign idx        = (rel >> IDX_SHIFT) & ~AW'(3);
  assign pte_addr_o = (base_i << BASE_SHIFT) + idx;
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check
  import dvma_pkg::*;
(
  input  logic [AW-1:0]         entry_i,
  input  logic                  is_write_i,
  input  logic [PAGE_SHIFT-1:0] off_i,
  output logic                  ok_o,
  output flt_code_e             code_o,
  output logic [AW-1:0]         pa_o,
  output logic                  cache_o
);
  localparam int unsigned PPN_W = PPN_HI - PPN_LO + 1;

  logic [PPN_W-1:0] ppn;
  logic             vld, wr;
  logic             unused_bits;

  assign ppn     = entry_i[PPN_HI:PPN_LO];
  assign vld     = entry_i[BIT_VALID];
  assign wr      = entry_i[BIT_WRITE];
  assign cache_o = entry_i[BIT_CACHE];
  assign pa_o    = AW'({ppn, off_i});

  // invalid takes precedence over write protection
  always_comb begin
    ok_o   = 1'b1;
    code_o = FLT_INVALID;
    if (!vld) begin
      ok_o   = 1'b0;
      code_o = FLT_INVALID;
    end else if (is_write_i && !wr) begin
      ok_o   = 1'b0;
      code_o = FLT_WPROT;
    end
  end

  assign unused_bits = ^{entry_i[AW-1:PPN_HI+1], entry_i[BIT_CACHE-1:BIT_WRITE+1], entry_i[0]};
endmodule

// File: rtl/dvma_chunk.sv
module dvma_chunk
  import dvma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic [PAGE_SHIFT-1:0] off_i,
  input  logic [LEN_W-1:0]      rem_i,
  output logic [LEN_W-1:0]      clen_o,
  output logic                  last_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_SHIFT;

  logic [LEN_W-1:0] to_bnd;

  assign to_bnd = LEN_W'(PAGE_BYTES) - LEN_W'(off_i);
  assign last_o = (rem_i <= to_bnd);
  assign clen_o = last_o ? rem_i : to_bnd;
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    dva_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             write_i,
  input  logic [AW-1:0]    win_start_i,
  input  logic [AW-1:0]    tbl_base_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             chunk_valid_o,
  output logic [AW-1:0]    chunk_pa_o,
  output logic [LEN_W-1:0] chunk_len_o,
  output logic             chunk_cache_o,
  output logic             fault_o,
  output logic [AW-1:0]    fault_dva_o,
  output logic             fault_code_o,
  output logic             done_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_SHIFT;

  xl_state_e        state_q;
  logic [AW-1:0]    dva_q, win_q, base_q;
  logic [LEN_W-1:0] rem_q;
  logic             wr_q;

  logic [LEN_W-1:0] clen;
  logic             last;
  logic             pte_ok, pte_cache;
  flt_code_e        pte_code;
  logic [AW-1:0]    pte_pa;

  dvma_pte_addr u_addr (
    .dva_i      (dva_q),
    .win_i      (win_q),
    .base_i     (base_q),
    .pte_addr_o (mem_addr_o)
  );

  dvma_chunk #(.LEN_W(LEN_W)) u_chunk (
    .off_i  (dva_q[PAGE_SHIFT-1:0]),
    .rem_i  (rem_q),
    .clen_o (clen),
    .last_o (last)
  );

  dvma_pte_check u_chk (
    .entry_i    (mem_rdata_i),
    .is_write_i (wr_q),
    .off_i      (dva_q[PAGE_SHIFT-1:0]),
    .ok_o       (pte_ok),
    .code_o     (pte_code),
    .pa_o       (pte_pa),
    .cache_o    (pte_cache)
  );

  assign busy_o    = (state_q != ST_IDLE);
  assign mem_req_o = (state_q == ST_FETCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      dva_q         <= '0;
      win_q         <= '0;
      base_q        <= '0;
      rem_q         <= '0;
      wr_q          <= 1'b0;
      chunk_valid_o <= 1'b0;
      chunk_pa_o    <= '0;
      chunk_len_o   <= '0;
      chunk_cache_o <= 1'b0;
      fault_o       <= 1'b0;
      fault_dva_o   <= '0;
      fault_code_o  <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      chunk_valid_o <= 1'b0;
      fault_o       <= 1'b0;
      done_o        <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            dva_q  <= dva_i;
            win_q  <= win_start_i;
            base_q <= tbl_base_i;
            rem_q  <= len_i;
            wr_q   <= write_i;
            if (len_i == '0) done_o <= 1'b1;
            else             state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack_i) begin
            if (!pte_ok) begin
              fault_o      <= 1'b1;
              fault_dva_o  <= dva_q;
              fault_code_o <= pte_code;
              state_q      <= ST_IDLE;
            end else begin
              chunk_valid_o <= 1'b1;
              chunk_pa_o    <= pte_pa;
              chunk_len_o   <= clen;
              chunk_cache_o <= pte_cache;
              dva_q         <= dva_q + AW'(clen);
              rem_q         <= rem_q - clen;
              if (last) begin
                done_o  <= 1'b1;
                state_q <= ST_IDLE;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_fault_alone_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!chunk_valid_o && !done_o && !busy_o));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_zero_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && len_i == '0) |=> (done_o && !chunk_valid_o && !mem_req_o));

  assert_chunk_fit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_valid_o |-> (chunk_len_o != '0 &&
      (LEN_W'(chunk_pa_o[PAGE_SHIFT-1:0]) + chunk_len_o) <= LEN_W'(PAGE_BYTES)));
endmodule

// File: tb/dvma_xlate_test.sv
`timescale 1ns/1ps
module dvma_xlate_test;
  import dvma_pkg::*;
  localparam int LEN_W = 16;

  typedef struct packed {
    logic        is_chunk;
    logic        is_fault;
    logic        is_done;
    logic [31:0] addr;
    logic [15:0] len;
    logic        code;
    logic        cache;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             start = 1'b0, wr = 1'b0;
  logic [31:0]      dva = '0, win = '0, base = '0;
  logic [LEN_W-1:0] len = '0;
  logic             busy, mreq, mack = 1'b0;
  logic [31:0]      maddr, mrdata = '0;
  logic             cval, ccache, flt, fcode, dn;
  logic [31:0]      cpa, fdva;
  logic [LEN_W-1:0] clen;

  dvma_xlate #(.LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dva_i(dva), .len_i(len),
    .write_i(wr), .win_start_i(win), .tbl_base_i(base), .busy_o(busy),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_ack_i(mack), .mem_rdata_i(mrdata),
    .chunk_valid_o(cval), .chunk_pa_o(cpa), .chunk_len_o(clen), .chunk_cache_o(ccache),
    .fault_o(flt), .fault_dva_o(fdva), .fault_code_o(fcode), .done_o(dn)
  );

  ev_t         ev_q[$];
  logic [31:0] fetch_q[$];
  logic [31:0] pte_mem[logic [31:0]];
  int checks = 0, fails = 0, lat = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_pte(input logic [31:0] a);
    if (pte_mem.exists(a)) return pte_mem[a];
    return {5'd0, a[20:2] ^ 19'h2a5c3, 8'h86};
  endfunction

  task automatic predict(input logic [31:0] d, input int n, input bit w,
                         input logic [31:0] ws, input logic [31:0] b);
    logic [31:0] a = d;
    int rem = n;
    ev_t e;
    if (rem == 0) begin
      e = '0; e.is_done = 1'b1; ev_q.push_back(e);
    end
    while (rem > 0) begin
      logic [31:0] pa, ent;
      int step;
      pa = b * 32'd16 + ((a & ~ws) / 32'd4096) * 32'd4;
      fetch_q.push_back(pa);
      ent = rd_pte(pa);
      e = '0;
      if (!ent[1] || (w && !ent[2])) begin
        e.is_fault = 1'b1; e.addr = a; e.code = ent[1];
        ev_q.push_back(e);
        return;
      end
      step = 4096 - int'(a % 32'd4096);
      if (step > rem) step = rem;
      e.is_chunk = 1'b1;
      e.addr = {13'd0, ent[26:8]} * 32'd4096 + a % 32'd4096;
      e.len = 16'(step);
      e.cache = ent[7];
      e.is_done = (step == rem);
      ev_q.push_back(e);
      a = a + 32'(step);
      rem = rem - step;
    end
  endtask

  // output monitor: every pulse is matched in order with the prediction
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (cval || flt || dn)) begin
        ev_t act, exp;
        string req;
        act = '0;
        act.is_chunk = cval; act.is_fault = flt; act.is_done = dn;
        if (cval) begin act.addr = cpa; act.len = clen; act.cache = ccache; end
        if (flt)  begin act.addr = fdva; act.code = fcode; end
        if (ev_q.size() == 0) begin
          chk(1'b0, "R5 R10 unexpected pulse", 64'(act), 64'd0);
        end else begin
          exp = ev_q.pop_front();
          if (exp.is_fault)      req = exp.code ? "R6 write-protect fault" : "R5 invalid fault";
          else if (!exp.is_chunk) req = "R7 zero length done";
          else if (exp.is_done)  req = "R8 R3 R4 last chunk";
          else                   req = "R3 R4 chunk";
          chk(act == exp, req, 64'(act), 64'(exp));
          if (dn || flt) chk(!busy, "R8 idle at end", 64'(busy), 64'd0);
        end
      end
    end
  end

  // memory responder with programmable latency
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mack) begin
        mack = 1'b0; cnt = 0;
      end else if (rst_n && mreq) begin
        if (cnt >= lat) begin
          logic [31:0] e = '0;
          if (fetch_q.size() != 0) e = fetch_q.pop_front();
          else chk(1'b0, "R5 R7 unexpected fetch", 64'(maddr), 64'd0);
          chk(maddr == e, "R2 entry address", 64'(maddr), 64'(e));
          mrdata = rd_pte(maddr);
          mack = 1'b1;
        end else cnt++;
      end
    end
  end

  task automatic run(input logic [31:0] d, input int n, input bit w,
                     input logic [31:0] ws, input logic [31:0] b, input bit poke);
    int t = 0;
    predict(d, n, w, ws, b);
    @(negedge clk);
    start = 1'b1; dva = d; len = LEN_W'(n); wr = w; win = ws; base = b;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: a start while busy must not add any event or fetch
      @(negedge clk);
      start = 1'b1; dva = 32'h1234_0000; len = '0; wr = 1'b0;
      @(negedge clk);
      start = 1'b1; len = 16'h0040;
      @(negedge clk);
      start = 1'b0;
    end
    while ((ev_q.size() != 0 || busy) && t < 5000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    chk(ev_q.size() == 0, "R8 all events seen", 64'(ev_q.size()), 64'd0);
    chk(fetch_q.size() == 0, "R5 R9 fetch count", 64'(fetch_q.size()), 64'd0);
    chk(!busy && !mreq, "R10 R8 idle after request", 64'({busy, mreq}), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    pte_mem[32'h0010_0014] = 32'h0001_2382; // valid, read-only, cacheable
    pte_mem[32'h0010_0020] = 32'h0000_0084; // invalid
    repeat (3) @(negedge clk);
    chk({busy, mreq, cval, flt, dn} == 5'b0, "R1 in reset", 64'({busy, mreq, cval, flt, dn}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, mreq, cval, flt, dn} == 5'b0, "R1 after reset", 64'({busy, mreq, cval, flt, dn}), 64'd0);

    lat = 0; run(32'hff00_0010, 100,     1'b0, 32'hff00_0000, 32'h0001_0000, 1'b0); // R3
    lat = 2; run(32'hff00_3f00, 'h2000,  1'b0, 32'hff00_0000, 32'h0001_0000, 1'b0); // R4 split
    lat = 1; run(32'hff00_4800, 'h1800,  1'b1, 32'hff00_0000, 32'h0001_0000, 1'b0); // R6 fault
    lat = 0; run(32'hff00_4800, 'h1800,  1'b0, 32'hff00_0000, 32'h0001_0000, 1'b0); // R6 read ok
    lat = 3; run(32'hff00_7ff0, 'h3000,  1'b0, 32'hff00_0000, 32'h0001_0000, 1'b0); // R5
    lat = 0; run(32'hff00_1000, 0,       1'b1, 32'hff00_0000, 32'h0001_0000, 1'b0); // R7
    lat = 3; run(32'h8123_4567, 'h1a99,  1'b1, 32'h8000_0000, 32'h0abc_0000, 1'b0); // R2 window
    lat = 1; run(32'hff00_a000, 'h1000,  1'b0, 32'hff00_0000, 32'h0001_0000, 1'b0); // R4 exact page
    lat = 2; run(32'hff00_b100, 'h1200,  1'b0, 32'hff00_0000, 32'h0001_0000, 1'b1); // R10
    lat = 1; run(32'hfe00_c000, 'h4000,  1'b1, 32'hfe00_0000, 32'h0002_0000, 1'b0); // R9 multi
    lat = 0; run(32'hff00_0ffe, 3,       1'b0, 32'hff00_0000, 32'h0001_0000, 1'b0); // R4 tiny split

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule